// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Channel

This block is one 8-bit up-counting timer channel with two compare registers. Software reaches it through a byte-wide register port. The port writes on a strobe and reads back combinationally by address. A prescaler divides the system clock to set the count rate. A three-bit rate index picks that rate. Two bits of the channel's control register form the upper part of the index, and a select bit from a register shared with other channels forms the lowest bit. Indices 0 and 1 stop the channel.

When the counter takes the value in a compare register, the matching status flag is set. If the enable bit for that match is on, a latched interrupt request is raised. A programmable clear mode can also return the counter to zero after a match on A or a match on B. Otherwise the counter runs freely and wraps, and the wrap sets an overflow flag. Writing the status register replaces its contents and withdraws every pending request of the channel.

Top module: `tmr8_channel`

## Requirements
- R1: After reset, the control, status, both compare registers and the counter read as 0x00, and the counter stays stopped; all three request outputs are low.
- R2: The rate index is {control[1:0], share_sel}. Indices 0 and 1 hold the counter and the prescaler. Indices 2, 3, 4, 5, 6 and 7 advance the counter once every 8, 2, 64, 32, 1024 and 256 clock cycles. The first advance comes that many cycles after the cycle in which the index becomes running.
- R3: Each advance adds one to the counter. A step from 0xFF to 0x00 sets status bit 5, and it raises irq_ovf when control bit 5 is 1.
- R4: When an advance makes the counter equal compare A, status bit 6 is set, and irq_cmp_a is raised only when control bit 6 is 1.
- R5: When an advance makes the counter equal compare B, status bit 7 is set, and irq_cmp_b is raised only when control bit 7 is 1.
- R6: Control bits [4:3] set the clear mode. Value 0 never clears. Value 1 makes the advance after a compare-A match load 0, and value 2 does the same after a compare-B match. Value 3 behaves like value 0. An advance that clears does not set the overflow flag.
- R7: A status write stores the written byte and drops all three requests.
- R8: A flag or request set by an event in the same cycle as a status write survives that write, OR-ed into the written byte.
- R9: Register addresses are: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter. Each one reads back what was last written to it. Other addresses read 0x00. A counter write takes precedence over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| share_sel | input | 1 | Select bit from the register shared between channels; lowest bit of the rate index |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| irq_cmp_a | output | 1 | Compare-A interrupt request |
| irq_cmp_b | output | 1 | Compare-B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Two things can land on the same clock edge: a software write of the status register, and a hardware compare match that sets a flag and raises a request. The bench provokes this by starting the channel at divide-by-2 with compare A at 1. It issues the status write so that the write takes effect on exactly the edge where the counter first reaches 1. It then reads status and irq_cmp_a and expects the written zero with bit 6 OR-ed in and the request still high.

// File: rtl/tmr8_pkg.sv
// Package: shared register map, clear-mode encoding and the rate-index
// decode for the 8-bit timer channel. Assumes a byte-wide register port.
package tmr8_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_CMP  = 2;
    localparam int NUM_IRQ  = 3;
    localparam int FLG_BASE = 5;   // status bits 5,6,7 = overflow, A, B
    localparam int IE_BASE  = 5;   // control bits 5,6,7 = their enables

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_CMPA  = 3'd2,
        REG_CMPB  = 3'd3,
        REG_COUNT = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_ON_A = 2'd1,
        CLR_ON_B = 2'd2,
        CLR_EXT  = 2'd3
    } clr_mode_e;

    // Log2 of the clock divide ratio for a running rate index; 0 when stopped.
    function automatic int div_shift(input logic [2:0] idx);
        case (idx)
            3'd2:    div_shift = 3;
            3'd3:    div_shift = 1;
            3'd4:    div_shift = 6;
            3'd5:    div_shift = 5;
            3'd6:    div_shift = 10;
            3'd7:    div_shift = 8;
            default: div_shift = 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
// Module: free-running clock divider producing a one-cycle advance pulse.
// Assumes PRE_W covers the largest divide shift; held at zero while stopped.
module tmr8_prescaler
    import tmr8_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_idx,
    output logic       tick
);

    logic             run;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign run = (sel_idx >= 3'd2);

    // Divider count: cleared on reset or while the rate index is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Low-bit mask selecting the divide ratio of the current index.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < div_shift(sel_idx));
    end

    assign tick = run && ((pre_q & mask) == mask);

endmodule

// File: rtl/tmr8_core.sv
// Module: the counter with its compare units and clear-mode handling.
// Assumes tick is a single-cycle advance pulse; a counter write wins over it.
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  clr_mode_e         clr_mode,
    output logic [CNT_W-1:0]  count,
    output logic [NUM_CMP-1:0] ev_match,
    output logic              ev_ovf
);

    logic [CNT_W-1:0] cmp_v [NUM_CMP];
    logic [CNT_W-1:0] nxt;
    logic             clear_now;
    logic             adv;

    assign cmp_v[0] = cmp_a;
    assign cmp_v[1] = cmp_b;
    assign adv      = tick && !cnt_wr;

    // Clear happens on the advance that follows the selected match.
    assign clear_now = ((clr_mode == CLR_ON_A) && (count == cmp_a)) ||
                       ((clr_mode == CLR_ON_B) && (count == cmp_b));
    assign nxt = clear_now ? '0 : count + 1'b1;

    // Counter register: write first, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= wdata;
        else if (tick)   count <= nxt;
    end

    // One compare unit per compare register.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign ev_match[g] = adv && (nxt == cmp_v[g]);
    end

    assign ev_ovf = adv && !clear_now && (count == {CNT_W{1'b1}});

endmodule

// File: rtl/tmr8_regs.sv
// Module: control, compare and status registers plus latched requests.
// Assumes events are single-cycle; an event beats a status write.
module tmr8_regs
    import tmr8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CMP-1:0] ev_match,
    input  logic               ev_ovf,
    output logic [DATA_W-1:0]  ctrl_q,
    output logic [DATA_W-1:0]  cmp_a_q,
    output logic [DATA_W-1:0]  cmp_b_q,
    output logic [DATA_W-1:0]  status_q,
    output logic [NUM_IRQ-1:0] irq_q
);

    logic [NUM_IRQ-1:0] ev_vec;
    logic [DATA_W-1:0]  set_mask;
    logic               stat_wr;

    assign ev_vec  = {ev_match[1], ev_match[0], ev_ovf};
    assign stat_wr = wr_en && (addr == REG_STAT);

    // Flag bits raised by this cycle's events.
    always_comb begin
        set_mask = '0;
        set_mask[FLG_BASE +: NUM_IRQ] = ev_vec;
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (wr_en) begin
            if (addr == REG_CTRL) ctrl_q  <= wdata;
            if (addr == REG_CMPA) cmp_a_q <= wdata;
            if (addr == REG_CMPB) cmp_b_q <= wdata;
        end
    end

    // Status: written byte or held value, with event flags OR-ed in.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (stat_wr) status_q <= wdata | set_mask;
        else              status_q <= status_q | set_mask;
    end

    // One latched request per source, gated by its enable bit.
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n)
                irq_q[k] <= 1'b0;
            else
                irq_q[k] <= (irq_q[k] && !stat_wr) ||
                            (ev_vec[k] && ctrl_q[IE_BASE + k]);
        end
    end

endmodule

// File: rtl/tmr8_channel.sv
// Module: top of the dual-compare 8-bit timer channel. Ties the prescaler,
// counter core and register file together and serves the read mux.
// Assumes share_sel is driven from a register outside this channel.
module tmr8_channel
    import tmr8_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        share_sel,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq_cmp_a,
    output logic        irq_cmp_b,
    output logic        irq_ovf
);

    logic [DATA_W-1:0]  ctrl_q, cmp_a_q, cmp_b_q, status_q, count_q;
    logic [NUM_CMP-1:0] ev_match;
    logic               ev_ovf;
    logic [NUM_IRQ-1:0] irq_q;
    logic [2:0]         sel_idx;
    logic               tick;
    logic               cnt_wr;

    assign sel_idx = {ctrl_q[1:0], share_sel};
    assign cnt_wr  = wr_en && (addr == REG_COUNT);

    tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_idx (sel_idx),
        .tick    (tick)
    );

    tmr8_core #(.CNT_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .wdata    (wdata),
        .cmp_a    (cmp_a_q),
        .cmp_b    (cmp_b_q),
        .clr_mode (clr_mode_e'(ctrl_q[4:3])),
        .count    (count_q),
        .ev_match (ev_match),
        .ev_ovf   (ev_ovf)
    );

    tmr8_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .ev_match (ev_match),
        .ev_ovf   (ev_ovf),
        .ctrl_q   (ctrl_q),
        .cmp_a_q  (cmp_a_q),
        .cmp_b_q  (cmp_b_q),
        .status_q (status_q),
        .irq_q    (irq_q)
    );

    // Read mux by register address.
    always_comb begin
        case (addr)
            REG_CTRL:  rdata = ctrl_q;
            REG_STAT:  rdata = status_q;
            REG_CMPA:  rdata = cmp_a_q;
            REG_CMPB:  rdata = cmp_b_q;
            REG_COUNT: rdata = count_q;
            default:   rdata = '0;
        endcase
    end

    assign irq_ovf   = irq_q[0];
    assign irq_cmp_a = irq_q[1];
    assign irq_cmp_b = irq_q[2];

endmodule

// File: rtl/tmr8_channel_chk.sv
// Module: property checker for tmr8_channel, attached by bind below.
// Assumes it sees the channel's internal state through the bind port map.
module tmr8_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [2:0] sel_idx,
    input logic       tick,
    input logic [7:0] count,
    input logic [7:0] cmp_a,
    input logic [7:0] ctrl,
    input logic [7:0] status,
    input logic [1:0] ev_match,
    input logic       ev_ovf,
    input logic       irq_a,
    input logic       irq_b,
    input logic       irq_o
);

    // R2: a stopped index with no counter write keeps the counter still.
    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx < 3'd2 && !(wr_en && addr == 3'd4)) |=> $stable(count));

    // R4: a new compare-A request always comes with its status flag.
    assert_irq_a_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> status[6]);

    // R5: a new compare-B request always comes with its status flag.
    assert_irq_b_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b) |-> status[7]);

    // R6: clear-on-A mode returns the counter to zero after a match.
    assert_clear_on_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr == 3'd4) && ctrl[4:3] == 2'b01 && count == cmp_a)
        |=> (count == 8'h00));

    // R7: a quiet status write withdraws every request.
    assert_stat_wr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && ev_match == 2'b00 && !ev_ovf)
        |=> (!irq_a && !irq_b && !irq_o));

    // R8: a compare-A event always leaves its flag set, status write or not.
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_match[0] |=> status[6]);

endmodule

bind tmr8_channel tmr8_channel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .sel_idx  (sel_idx),
    .tick     (tick),
    .count    (count_q),
    .cmp_a    (cmp_a_q),
    .ctrl     (ctrl_q),
    .status   (status_q),
    .ev_match (ev_match),
    .ev_ovf   (ev_ovf),
    .irq_a    (irq_cmp_a),
    .irq_b    (irq_cmp_b),
    .irq_o    (irq_ovf)
);

// File: tb/tmr8_channel_test.sv
// Bench: rate table walked by one loop, then directed tests for the
// flags, requests, clear modes and corner cases.
module tmr8_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       share_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_cmp_a, irq_cmp_b, irq_ovf;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CMPA = 3'd2,
                           A_CMPB = 3'd3, A_CNT = 3'd4;

    typedef struct packed {
        logic        share;
        logic [1:0]  cs;
        logic [15:0] n;
        logic [7:0]  exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd1, 16'd100,  8'd12},   // /8
        '{1'b1, 2'd1, 16'd100,  8'd50},   // /2
        '{1'b0, 2'd2, 16'd200,  8'd3},    // /64
        '{1'b1, 2'd2, 16'd200,  8'd6},    // /32
        '{1'b0, 2'd3, 16'd3000, 8'd2},    // /1024
        '{1'b1, 2'd3, 16'd600,  8'd2},    // /256
        '{1'b1, 2'd0, 16'd50,   8'd0},    // index 1: stopped
        '{1'b0, 2'd0, 16'd50,   8'd0},    // index 0: stopped
        '{1'b1, 2'd1, 16'd600,  8'd44}    // /2 with wrap
    };

    tmr8_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .share_sel (share_sel),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_cmp_a (irq_cmp_a),
        .irq_cmp_b (irq_cmp_b),
        .irq_ovf   (irq_ovf)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic halt_and_clear();
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h00);
        wr(A_STAT, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 reset register", v, 8'h00);
        end
        check("R1 reset irqs", {5'b0, irq_cmp_a, irq_cmp_b, irq_ovf}, 8'h00);
        repeat (20) @(negedge clk);
        rd(A_CNT, v); check("R1 stays stopped", v, 8'h00);

        // R2: rate table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 8'h00);
            wr(A_CNT, 8'h00);
            share_sel = VECS[i].share;
            wr(A_CTRL, {6'b0, VECS[i].cs});
            repeat (int'(VECS[i].n)) @(negedge clk);
            rd(A_CNT, v); check("R2 rate index count", v, VECS[i].exp);
        end

        // R4, R5: flags and gated requests
        share_sel = 1'b1;
        halt_and_clear();
        wr(A_CMPA, 8'd5); wr(A_CMPB, 8'd3);
        wr(A_CTRL, 8'h41);
        repeat (12) @(negedge clk);
        rd(A_CNT, v);  check("R3 count advance", v, 8'd6);
        rd(A_STAT, v); check("R4 R5 status flags", v, 8'hC0);
        check("R4 irq_cmp_a enabled", {7'b0, irq_cmp_a}, 8'h01);
        check("R5 irq_cmp_b disabled", {7'b0, irq_cmp_b}, 8'h00);

        // R7: status write replaces and withdraws
        wr(A_STAT, 8'h00);
        check("R7 irq dropped", {5'b0, irq_cmp_a, irq_cmp_b, irq_ovf}, 8'h00);
        wr(A_STAT, 8'h1A);
        rd(A_STAT, v); check("R7 status replaced", v, 8'h1A);

        // R6: clear on match A
        halt_and_clear();
        wr(A_CMPA, 8'd4); wr(A_CMPB, 8'hFF);
        wr(A_CTRL, 8'h09);
        repeat (23) @(negedge clk);
        rd(A_CNT, v);  check("R6 clear on A count", v, 8'd1);
        rd(A_STAT, v); check("R6 clear on A flags", v, 8'h40);

        // R6: clear on match B
        halt_and_clear();
        wr(A_CMPA, 8'd2); wr(A_CMPB, 8'd6);
        wr(A_CTRL, 8'h11);
        repeat (31) @(negedge clk);
        rd(A_CNT, v); check("R6 clear on B count", v, 8'd1);

        // R6: mode 3 never clears
        halt_and_clear();
        wr(A_CMPA, 8'd2);
        wr(A_CTRL, 8'h19);
        repeat (40) @(negedge clk);
        rd(A_CNT, v); check("R6 mode 3 no clear", v, 8'd20);

        // R3: wrap and overflow request
        halt_and_clear();
        wr(A_CNT, 8'hFE);
        wr(A_CMPA, 8'h10); wr(A_CMPB, 8'h10);
        wr(A_CTRL, 8'h21);
        repeat (4) @(negedge clk);
        rd(A_CNT, v);  check("R3 wrap count", v, 8'h00);
        rd(A_STAT, v); check("R3 overflow flag", v, 8'h20);
        check("R3 irq_ovf", {7'b0, irq_ovf}, 8'h01);

        // R8: status write on the same edge as a compare-A match
        halt_and_clear();
        wr(A_CMPA, 8'd1);
        wr(A_CTRL, 8'h41);
        wr(A_STAT, 8'h00);
        rd(A_CNT, v);  check("R8 count at match", v, 8'd1);
        rd(A_STAT, v); check("R8 flag survives write", v, 8'h40);
        check("R8 irq survives write", {7'b0, irq_cmp_a}, 8'h01);

        // R9: register readback and counter write
        halt_and_clear();
        wr(A_CMPA, 8'hA5); wr(A_CMPB, 8'h5A); wr(A_CTRL, 8'h9C);
        rd(A_CMPA, v); check("R9 compare A readback", v, 8'hA5);
        rd(A_CMPB, v); check("R9 compare B readback", v, 8'h5A);
        rd(A_CTRL, v); check("R9 control readback", v, 8'h9C);
        rd(3'd5, v);   check("R9 unused address", v, 8'h00);
        wr(A_CTRL, 8'h01);
        repeat (3) @(negedge clk);
        wr(A_CNT, 8'h33);
        rd(A_CNT, v);  check("R9 counter write", v, 8'h33);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule